// File: doc/BRIEF.md
# Strobe-Driven Setup Register Port

This block is the device side of a small configuration port. An external host reaches sixteen 12-bit setup registers through four signals: an active-low select, an active-low write line, a 5-bit address and a 12-bit data bus shared by both directions. The select and write strobes are sampled on the master clock through two-flop synchronisers. A transaction is framed by the edges of the synchronised select, and the block needs no asynchronous logic.

A write commits on the trailing (rising) select edge if the write line is low at that moment. A read starts on the leading (falling) select edge if the write line is high. The register value is captured at that edge and driven for the whole low phase of the select.

The port answers only while the device is in master mode. It flags a host that moves the write line during a transaction. All register contents are presented to the rest of the chip as one packed vector. The shared bus is modelled as separate input and output halves plus an output enable, and the pad tri-state is built from those.

Top module: `setup_reg_port`

## Requirements
- R1: After reset all sixteen registers read as zero, the output enable is low and the error flag is low.
- R2: In master mode, a rising edge of `csN` with `wrN` low stores `dataIn` into the register selected by `addr` (0x00 to 0x0F). The new value appears on `regFlat` within four master clocks of the edge.
- R3: In master mode, a falling edge of `csN` with `wrN` high raises `dataOe` exactly three master clocks after the `csN` edge (two synchroniser stages and one register). `dataOe` falls exactly two master clocks after `csN` returns high.
- R4: An address with bit 4 set (0x10 to 0x1F) names no register. A write there changes no register, and a read there drives zero on `dataOut`.
- R5: While `masterMode` is low, strobes are ignored: no register changes, `dataOe` stays low and the error flag does not set.
- R6: A change of `wrN` while `csN` is low in master mode sets `protoErr`. The flag stays set until reset.
- R7: A write transaction in which `wrN` changed during the low phase commits nothing.
- R8: While `dataOe` is high, `dataOut` holds the value captured at the start of the read, and it equals the addressed register's content at that time.
- R9: Register n is presented on `regFlat[12n+11:12n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low asynchronous reset |
| masterMode | input | 1 | High when the device is in master mode; gates all access |
| csN | input | 1 | Active-low select strobe from the host |
| wrN | input | 1 | Active-low write line; high selects a read |
| addr | input | 5 | Register address |
| dataIn | input | 12 | Write data from the shared bus |
| dataOut | output | 12 | Read data toward the shared bus |
| dataOe | output | 1 | Drive enable for the shared bus |
| regFlat | output | 192 | All register contents, register n at bits 12n+11 down to 12n |
| protoErr | output | 1 | Sticky flag: write line moved during a transaction |

## Verification
The bench mixes random reads and writes over the full 5-bit address range and both modes with directed cases. Those cases cover the exact enable timing on both select edges, writes and reads above 0x0F, and write-line toggles during reads and during writes. A design that decoded only four address bits would alias 0x1n onto register n, so a later readback would differ from the model. A design that committed on the falling edge, ignored the mode, or missed a toggle would show a register value or error flag that the bench model does not predict. An enable that is off by one clock fails the strict edge samples.

// File: rtl/setup_reg_pkg.sv
package setup_reg_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 12;
  localparam int NUM_REGS = 16;

  typedef struct packed {
    logic readStart;   // synchronised select fell, read requested
    logic writeCommit; // synchronised select rose, write accepted
    logic selHigh;     // synchronised select is deasserted
  } portStrobes_t;
endpackage

// File: rtl/setup_reg_ctrl.sv
module setup_reg_ctrl
  import setup_reg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         masterMode,
  input  logic         csN,
  input  logic         wrN,
  output portStrobes_t strb,
  output logic         protoErr
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] wrPipe;
  logic csSync, wrSync, csPrev, wrPrev;
  logic selFell, selRose, wrMoved, txnBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe <= '1;
      wrPipe <= '1;
      csPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      csPipe <= {csPipe[SYNC_STAGES-2:0], csN};
      wrPipe <= {wrPipe[SYNC_STAGES-2:0], wrN};
      csPrev <= csPipe[SYNC_STAGES-1];
      wrPrev <= wrPipe[SYNC_STAGES-1];
    end
  end

  assign csSync  = csPipe[SYNC_STAGES-1];
  assign wrSync  = wrPipe[SYNC_STAGES-1];
  assign selFell = csPrev && !csSync;
  assign selRose = !csPrev && csSync;
  assign wrMoved = masterMode && !csSync && !csPrev && (wrSync != wrPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txnBad   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      if (selFell)
        txnBad <= 1'b0;
      else if (wrMoved)
        txnBad <= 1'b1;
      if (wrMoved)
        protoErr <= 1'b1;
    end
  end

  always_comb begin
    strb             = '0;
    strb.readStart   = masterMode && selFell && wrSync;
    strb.writeCommit = masterMode && selRose && !wrSync && !txnBad;
    strb.selHigh     = csSync;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R6
  AST_NO_READ_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.readStart && strb.writeCommit)); // R2
  AST_BAD_TXN_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    txnBad |-> !strb.writeCommit); // R7
  AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> !strb.readStart && !strb.writeCommit); // R5
endmodule

// File: rtl/setup_reg_dpath.sv
module setup_reg_dpath
  import setup_reg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       masterMode,
  input  portStrobes_t               strb,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] rdData;
  logic              oeReg;
  logic              addrOk;
  logic [IDX_W-1:0]  idx;

  assign addrOk = (addr < ADDR_W'(NUM_REGS));
  assign idx    = addr[IDX_W-1:0];

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[n] <= '0;
      else if (strb.writeCommit && addrOk && idx == IDX_W'(n))
        regFile[n] <= dataIn;
    end
    assign regFlat[n*DATA_W +: DATA_W] = regFile[n];

    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !strb.writeCommit |=> $stable(regFile[n])); // R2
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      oeReg  <= 1'b0;
    end else begin
      if (strb.readStart)
        rdData <= addrOk ? regFile[idx] : '0;
      if (strb.selHigh)
        oeReg <= 1'b0;
      else if (strb.readStart)
        oeReg <= 1'b1;
    end
  end

  assign dataOe  = oeReg && !strb.selHigh && masterMode;
  assign dataOut = rdData;

  AST_HIGH_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.readStart && !addrOk |=> rdData == '0); // R4
  AST_READ_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    oeReg && !strb.selHigh |=> $stable(rdData)); // R8
  AST_OE_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeReg) |-> $past(strb.readStart)); // R3
endmodule

// File: rtl/setup_reg_port.sv
module setup_reg_port
  import setup_reg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       masterMode,
  input  logic                       csN,
  input  logic                       wrN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat,
  output logic                       protoErr
);
  portStrobes_t strb;

  setup_reg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .csN        (csN),
    .wrN        (wrN),
    .strb       (strb),
    .protoErr   (protoErr)
  );

  setup_reg_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .strb       (strb),
    .addr       (addr),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .regFlat    (regFlat)
  );
endmodule

// File: tb/setup_reg_port_bench.sv
module setup_reg_port_bench;
  localparam int NR = 16;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic csN = 1'b1;
  logic wrN = 1'b1;
  logic [4:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOe;
  logic [NR*DW-1:0] regFlat;
  logic protoErr;

  int compared = 0;
  int mismatched = 0;
  logic [DW-1:0] model [NR];
  logic errModel = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  setup_reg_port u_setup_reg_port (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .csN(csN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .regFlat(regFlat), .protoErr(protoErr));

  function automatic logic [DW-1:0] expRead(input logic [4:0] a);
    return a[4] ? '0 : model[a[3:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < NR; i++)
      check(req, 32'(regFlat[i*DW +: DW]), 32'(model[i]));
    check("R6", 32'(protoErr), 32'(errModel));
  endtask

  // R2 R4 R5 R7: write transaction, optional write-line toggle during low phase
  task automatic doWrite(input logic [4:0] a, input logic [DW-1:0] d, input logic mode, input logic tog);
    masterMode = mode; addr = a; dataIn = d; wrN = 1'b0;
    tick(2);
    csN = 1'b0;
    tick(3);
    if (tog) begin
      wrN = 1'b1; tick(3); wrN = 1'b0; tick(3);
    end
    csN = 1'b1;
    tick(5);
    wrN = 1'b1;
    tick(2);
    if (mode && tog) errModel = 1'b1;
    if (mode && !tog && !a[4]) model[a[3:0]] = d;
    checkRegs(tog ? "R7" : (mode ? (a[4] ? "R4" : "R2") : "R5"));
  endtask

  // R3 R4 R5 R8: read transaction with strict enable timing
  task automatic doRead(input logic [4:0] a, input logic mode, input logic tog);
    logic [DW-1:0] exp;
    masterMode = mode; addr = a; wrN = 1'b1;
    exp = expRead(a);
    tick(2);
    csN = 1'b0;
    tick(2);
    check("R3", 32'(dataOe), 32'd0);
    tick(1);
    check(mode ? "R3" : "R5", 32'(dataOe), 32'(mode));
    if (mode) check(a[4] ? "R4" : "R8", 32'(dataOut), 32'(exp));
    if (tog) begin
      wrN = 1'b0; tick(3); wrN = 1'b1; tick(3);
      if (mode) errModel = 1'b1;
    end
    tick(2);
    if (mode) check("R8", 32'(dataOut), 32'(exp));
    check("R3", 32'(dataOe), 32'(mode));
    csN = 1'b1;
    tick(1);
    check("R3", 32'(dataOe), 32'(mode));
    tick(1);
    check("R3", 32'(dataOe), 32'd0);
    tick(2);
    check("R6", 32'(protoErr), 32'(errModel));
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    void'($urandom(32'd1357));
    tick(3);
    rstN = 1'b1;
    tick(2);
    checkRegs("R1");
    check("R1", 32'(dataOe), 32'd0);

    // directed corners
    doWrite(5'h03, 12'hABC, 1'b1, 1'b0);
    doWrite(5'h0F, 12'hFFF, 1'b1, 1'b0);
    check("R9", 32'(regFlat[15*DW +: DW]), 32'hFFF);
    doRead(5'h03, 1'b1, 1'b0);
    doWrite(5'h13, 12'h111, 1'b1, 1'b0);  // would alias register 3
    doRead(5'h13, 1'b1, 1'b0);
    doWrite(5'h05, 12'h555, 1'b0, 1'b0);  // not master
    doRead(5'h03, 1'b0, 1'b0);
    check("R5", 32'(protoErr), 32'd0);
    doWrite(5'h07, 12'h777, 1'b0, 1'b1);  // toggle outside master mode
    doWrite(5'h06, 12'h666, 1'b1, 1'b1);  // toggled write
    doWrite(5'h06, 12'h0A6, 1'b1, 1'b0);
    doRead(5'h06, 1'b1, 1'b1);            // toggled read still drives data

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic [4:0] ra;
      logic [DW-1:0] rd;
      logic rm, rt;
      ra = 5'($urandom_range(0, 31));
      rd = DW'($urandom);
      rm = ($urandom_range(0, 9) != 0);
      rt = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 1) == 0) doWrite(ra, rd, rm, rt);
      else doRead(ra, rm, rt);
    end
    checkRegs("R9");
    done = 1'b1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hang expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule